// File: doc/BRIEF.md
# CAN command register processor

This block is the command front end of a CAN controller. Software writes one-shot command words over a simple register port. Each set bit starts an action and is never stored, and a read of the port always returns zero. The block turns these writes into control of three transmit buffers and of a two-entry receive queue. It also owns two status flags: one says a received frame is waiting, the other says a frame was lost.

A send command takes the buffers named by the select lines and reduces them to one buffer. It does this either by lowest index or by the smallest 8-bit priority value, with ties going to the lower index. The chosen buffer is held pending until the bit engine reports ready. It is then started with a one-cycle strobe and stays active until the engine reports done. A cancel command drops the pending buffer only if the select lines name it and it has not started yet. A loop-back send behaves like a send, except the receiver stays enabled while the frame is on the bus.

The receive side counts completed frames from the acceptance filter. A release command frees the oldest frame. A frame that arrives while the queue is full is dropped and raises the overrun flag, which a separate command clears. After every accepted write, the next cycle is a dead cycle in which any write is discarded.

Top module: `can_cmd_proc`

## Requirements
- R1: `cmd_rdata_o` is zero at all times. After reset, `rbs_o`, `dor_o`, `tx_busy_o` and `tx_start_o` are 0, and `rx_en_o` is 1.
- R2: Command bits are: bit 0 send, bit 1 cancel, bit 2 release receive, bit 3 clear overrun, bit 4 loop-back send. Any write (even all zeros) arriving the cycle after an accepted write is discarded with no effect. Any other write is accepted.
- R3: With `prio_mode_i`=0, a send picks the lowest set index in `tx_sel_i`.
- R4: With `prio_mode_i`=1, a send picks the selected buffer with the smallest priority field. Buffer i uses bits [8i+7:8i] of `tx_prio_i`. On equal fields, the lower index wins.
- R5: A send with `tx_sel_i`=0 is ignored. A send while a transmission is pending or active is ignored, and the pending buffer index does not change.
- R6: A pending buffer raises `tx_start_o` (combinational) with `tx_idx_o` in the first cycle `eng_ready_i` is 1. It then stays active (`tx_busy_o`=1) until a cycle with `tx_done_i`=1.
- R7: A cancel removes a pending buffer if the pending buffer's bit in `tx_sel_i` is set. A cancel wins over `eng_ready_i` in the same cycle. A cancel of another buffer, or a cancel during an active transmission, has no effect.
- R8: While a plain send is active, `rx_en_o` is 0. While a loop-back send is active, `rx_en_o` stays 1 and `tx_self_o` is 1.
- R9: `rbs_o` is 1 while the receive queue holds a frame. An accepted release of a non-empty queue pulses `rx_release_o` in the write cycle and frees one entry. A release of an empty queue gives no pulse and leaves `rbs_o` at 0.
- R10: A frame arriving while the queue holds 2 frames, with no release in the same cycle, is dropped and sets `dor_o`. A release in the same cycle makes room, so the frame is kept and no overrun occurs.
- R11: A clear-overrun command clears `dor_o`. A new overrun in the same cycle wins, and `dor_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_wdata_i | input | 5 | Command bits |
| cmd_rdata_o | output | 5 | Read data of command port, always zero |
| tx_sel_i | input | 3 | Transmit buffer select bits |
| tx_prio_i | input | 24 | Per-buffer 8-bit priority fields |
| prio_mode_i | input | 1 | 0: index order, 1: priority field order |
| eng_ready_i | input | 1 | Bit engine can start a frame |
| tx_done_i | input | 1 | Bit engine finished or dropped the frame |
| rx_frame_i | input | 1 | Accepted frame completed on the receive side |
| tx_start_o | output | 1 | Start strobe for the bit engine |
| tx_idx_o | output | 2 | Pending or active buffer index |
| tx_self_o | output | 1 | Current transmission is a loop-back send |
| tx_busy_o | output | 1 | A transmission is pending or active |
| rx_en_o | output | 1 | Receiver enable qualifier |
| rx_release_o | output | 1 | Frees the oldest stored frame |
| rbs_o | output | 1 | Receive buffer status |
| dor_o | output | 1 | Data overrun flag |

## Verification
The bench uses the default build: three transmit buffers, 8-bit priority fields and a receive queue two deep. With these sizes the arbiter can be swept exhaustively. Every select pattern is combined with all 64 assignments of four spread priority values, including the extremes 0 and 255, in both modes. Ties and single-buffer picks therefore all occur. The shallow queue makes the full, overrun, release-on-full and release-on-empty states reachable in a few frames. This lets the bench pin down the dead cycle and the set-over-clear ordering at exact cycles.

// File: rtl/can_cmd_pkg.sv
package can_cmd_pkg;
  localparam int CMD_W   = 5;
  localparam int CMD_TR  = 0;
  localparam int CMD_AT  = 1;
  localparam int CMD_RRB = 2;
  localparam int CMD_CDO = 3;
  localparam int CMD_SRR = 4;

  typedef struct packed {
    logic send;
    logic cancel;
    logic release_rx;
    logic clear_ovr;
    logic loopback;
  } cmd_t;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PEND = 2'd1,
    TX_ACT  = 2'd2
  } tx_state_e;

  typedef enum logic {
    ARB_INDEX = 1'b0,
    ARB_FIELD = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/can_cmd_decode.sv
module can_cmd_decode
  import can_cmd_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CMD_W-1:0] wdata_i,
  output logic             acc_o,
  output cmd_t             cmd_o
);
  logic gap_q;

  assign acc_o = we_i & ~gap_q;

  always_comb begin
    cmd_o            = '0;
    cmd_o.send       = acc_o & wdata_i[CMD_TR];
    cmd_o.cancel     = acc_o & wdata_i[CMD_AT];
    cmd_o.release_rx = acc_o & wdata_i[CMD_RRB];
    cmd_o.clear_ovr  = acc_o & wdata_i[CMD_CDO];
    cmd_o.loopback   = acc_o & wdata_i[CMD_SRR];
  end

  // one dead cycle after each accepted write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gap_q <= 1'b0;
    else         gap_q <= acc_o;
  end

  a_r2_gap_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> !acc_o);
  a_r2_write_after_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_o && we_i) |=> (!we_i || acc_o));
endmodule

// File: rtl/can_tx_arb.sv
module can_tx_arb
  import can_cmd_pkg::*;
#(
  parameter int NUM_TXB = 3,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = (NUM_TXB > 1) ? $clog2(NUM_TXB) : 1
) (
  input  logic [NUM_TXB-1:0]        sel_i,
  input  logic [NUM_TXB*PRIO_W-1:0] prio_i,
  input  arb_mode_e                 mode_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          idx_o
);
  logic [PRIO_W-1:0] prio_a [NUM_TXB];

  for (genvar g = 0; g < NUM_TXB; g++) begin : g_unpack
    assign prio_a[g] = prio_i[g*PRIO_W +: PRIO_W];
  end

  logic [PRIO_W-1:0] best;

  // strict compare keeps ties on the lower index
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    best    = '1;
    for (int i = 0; i < NUM_TXB; i++) begin
      if (sel_i[i] && (!valid_o || (mode_i == ARB_FIELD && prio_a[i] < best))) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        best    = prio_a[i];
      end
    end
  end

  always_comb begin
    a_r5_valid_iff_sel: assert (valid_o == (sel_i != '0));
    if (valid_o) a_r3_pick_selected: assert (sel_i[idx_o]);
  end
endmodule

// File: rtl/can_tx_ctrl.sv
module can_tx_ctrl
  import can_cmd_pkg::*;
#(
  parameter int NUM_TXB = 3,
  localparam int IDX_W  = (NUM_TXB > 1) ? $clog2(NUM_TXB) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               send_i,
  input  logic               loop_i,
  input  logic               cancel_i,
  input  logic [NUM_TXB-1:0] sel_i,
  input  logic               arb_valid_i,
  input  logic [IDX_W-1:0]   arb_idx_i,
  input  logic               eng_ready_i,
  input  logic               tx_done_i,
  output logic               tx_start_o,
  output logic [IDX_W-1:0]   tx_idx_o,
  output logic               tx_self_o,
  output logic               tx_busy_o,
  output logic               rx_en_o
);
  tx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             self_q, self_d;
  logic             cancel_hit;

  assign cancel_hit = cancel_i && sel_i[idx_q];

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    self_d  = self_q;
    unique case (state_q)
      TX_IDLE: if ((send_i || loop_i) && arb_valid_i) begin
        state_d = TX_PEND;
        idx_d   = arb_idx_i;
        self_d  = loop_i;
      end
      TX_PEND: begin
        if (cancel_hit)       state_d = TX_IDLE;
        else if (eng_ready_i) state_d = TX_ACT;
      end
      TX_ACT:  if (tx_done_i) state_d = TX_IDLE;
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      idx_q   <= '0;
      self_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      self_q  <= self_d;
    end
  end

  assign tx_start_o = (state_q == TX_PEND) && eng_ready_i && !cancel_hit;
  assign tx_idx_o   = idx_q;
  assign tx_busy_o  = (state_q != TX_IDLE);
  assign tx_self_o  = tx_busy_o && self_q;
  assign rx_en_o    = !((state_q == TX_ACT) && !self_q);

  a_r6_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_ACT && !tx_done_i) |=> (state_q == TX_ACT));
  a_r5_idx_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_o |=> (!tx_busy_o || $stable(tx_idx_o)));
  a_r8_plain_rx_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && !tx_self_o) |=> !rx_en_o);
  a_r8_loop_rx_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start_o && tx_self_o) |=> rx_en_o);
  a_r7_cancel_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TX_PEND && cancel_i && sel_i[tx_idx_o]) |-> !tx_start_o ##1 !tx_busy_o);
endmodule

// File: rtl/can_rx_status.sv
module can_rx_status #(
  parameter int RX_DEPTH = 2,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_frame_i,
  input  logic release_i,
  input  logic clear_ovr_i,
  output logic rx_release_o,
  output logic rbs_o,
  output logic dor_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(RX_DEPTH);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full, push, ovr;

  assign full         = (cnt_q == FULL);
  assign rx_release_o = release_i && (cnt_q != '0);
  assign push         = rx_frame_i && (!full || rx_release_o);
  assign ovr          = rx_frame_i && full && !rx_release_o;

  always_comb begin
    cnt_d = cnt_q;
    if (push && !rx_release_o)      cnt_d = cnt_q + 1'b1;
    else if (!push && rx_release_o) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dor_o <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (ovr)              dor_o <= 1'b1;
      else if (clear_ovr_i) dor_o <= 1'b0;
    end
  end

  assign rbs_o = (cnt_q != '0);

  a_r9_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  a_r9_empty_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_i && !rbs_o) |-> !rx_release_o);
  a_r10_ovr_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_frame_i && full && !release_i) |=> dor_o);
  a_r11_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_ovr_i && !rx_frame_i) |=> !dor_o);
endmodule

// File: rtl/can_cmd_proc.sv
module can_cmd_proc
  import can_cmd_pkg::*;
#(
  parameter int NUM_TXB  = 3,
  parameter int PRIO_W   = 8,
  parameter int RX_DEPTH = 2,
  localparam int IDX_W   = (NUM_TXB > 1) ? $clog2(NUM_TXB) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cmd_we_i,
  input  logic [CMD_W-1:0]          cmd_wdata_i,
  output logic [CMD_W-1:0]          cmd_rdata_o,
  input  logic [NUM_TXB-1:0]        tx_sel_i,
  input  logic [NUM_TXB*PRIO_W-1:0] tx_prio_i,
  input  logic                      prio_mode_i,
  input  logic                      eng_ready_i,
  input  logic                      tx_done_i,
  input  logic                      rx_frame_i,
  output logic                      tx_start_o,
  output logic [IDX_W-1:0]          tx_idx_o,
  output logic                      tx_self_o,
  output logic                      tx_busy_o,
  output logic                      rx_en_o,
  output logic                      rx_release_o,
  output logic                      rbs_o,
  output logic                      dor_o
);
  cmd_t             cmd;
  logic             cmd_acc;
  logic             arb_valid;
  logic [IDX_W-1:0] arb_idx;
  arb_mode_e        mode;

  assign cmd_rdata_o = '0;
  assign mode        = arb_mode_e'(prio_mode_i);

  can_cmd_decode u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cmd_we_i),
    .wdata_i (cmd_wdata_i),
    .acc_o   (cmd_acc),
    .cmd_o   (cmd)
  );

  can_tx_arb #(.NUM_TXB(NUM_TXB), .PRIO_W(PRIO_W)) u_arb (
    .sel_i   (tx_sel_i),
    .prio_i  (tx_prio_i),
    .mode_i  (mode),
    .valid_o (arb_valid),
    .idx_o   (arb_idx)
  );

  can_tx_ctrl #(.NUM_TXB(NUM_TXB)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .send_i      (cmd.send),
    .loop_i      (cmd.loopback),
    .cancel_i    (cmd.cancel),
    .sel_i       (tx_sel_i),
    .arb_valid_i (arb_valid),
    .arb_idx_i   (arb_idx),
    .eng_ready_i (eng_ready_i),
    .tx_done_i   (tx_done_i),
    .tx_start_o  (tx_start_o),
    .tx_idx_o    (tx_idx_o),
    .tx_self_o   (tx_self_o),
    .tx_busy_o   (tx_busy_o),
    .rx_en_o     (rx_en_o)
  );

  can_rx_status #(.RX_DEPTH(RX_DEPTH)) u_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_frame_i   (rx_frame_i),
    .release_i    (cmd.release_rx),
    .clear_ovr_i  (cmd.clear_ovr),
    .rx_release_o (rx_release_o),
    .rbs_o        (rbs_o),
    .dor_o        (dor_o)
  );

  a_r1_idle_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_busy_o) |-> (rx_en_o && !tx_start_o));
  a_r2_gap_blocks_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_acc |=> !rx_release_o);
endmodule

// File: tb/can_cmd_proc_test.sv
`timescale 1ns/1ps
module can_cmd_proc_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0;
  logic [4:0]  cmd_wdata_i = '0;
  logic [4:0]  cmd_rdata_o;
  logic [2:0]  tx_sel_i = '0;
  logic [23:0] tx_prio_i = '0;
  logic        prio_mode_i = 1'b0;
  logic        eng_ready_i = 1'b0;
  logic        tx_done_i = 1'b0;
  logic        rx_frame_i = 1'b0;
  logic        tx_start_o;
  logic [1:0]  tx_idx_o;
  logic        tx_self_o, tx_busy_o, rx_en_o, rx_release_o, rbs_o, dor_o;

  int nvec = 0;
  int nerr = 0;
  logic last_rel;

  always #2 clk_i = ~clk_i;

  can_cmd_proc uut (.*);

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    nerr++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  // one write cycle followed by an idle (gap) cycle
  task automatic wr(logic [4:0] bits);
    @(negedge clk_i);
    cmd_we_i = 1'b1; cmd_wdata_i = bits;
    #1;
    last_rel = rx_release_o;
    chk("R1 rdata", int'(cmd_rdata_o), 0);
    @(negedge clk_i);
    cmd_we_i = 1'b0; cmd_wdata_i = '0;
  endtask

  task automatic frame();
    @(negedge clk_i); rx_frame_i = 1'b1;
    @(negedge clk_i); rx_frame_i = 1'b0;
  endtask

  task automatic finish_tx();
    @(negedge clk_i); tx_done_i = 1'b1;
    @(negedge clk_i); tx_done_i = 1'b0;
    #1 chk("R6 idle after done", int'(tx_busy_o), 0);
  endtask

  initial begin
    int exp_idx, best_key, key, pv;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 rbs", int'(rbs_o), 0);
    chk("R1 dor", int'(dor_o), 0);
    chk("R1 busy", int'(tx_busy_o), 0);
    chk("R1 start", int'(tx_start_o), 0);
    chk("R1 rx_en", int'(rx_en_o), 1);
    chk("R1 rdata", int'(cmd_rdata_o), 0);
    rst_ni = 1'b1;

    // R3/R4 exhaustive arbitration sweep
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 64; p++) begin
        for (int s = 0; s < 8; s++) begin
          prio_mode_i = m[0];
          tx_sel_i    = s[2:0];
          for (int b = 0; b < 3; b++) begin
            pv = ((p >> (2*b)) & 3) * 85;
            tx_prio_i[b*8 +: 8] = pv[7:0];
          end
          exp_idx = -1; best_key = 1 << 20;
          for (int b = 0; b < 3; b++) begin
            if (s[b]) begin
              key = (m == 1) ? (((p >> (2*b)) & 3) * 85 * 4 + b) : b;
              if (key < best_key) begin best_key = key; exp_idx = b; end
            end
          end
          wr(5'h01);
          eng_ready_i = 1'b1;
          #1;
          if (s == 0) begin
            chk("R5 empty select no start", int'(tx_start_o), 0);
            chk("R5 empty select idle", int'(tx_busy_o), 0);
            @(negedge clk_i); eng_ready_i = 1'b0;
          end else begin
            chk("R6 start", int'(tx_start_o), 1);
            chk(m ? "R4 field pick" : "R3 index pick", int'(tx_idx_o), exp_idx);
            @(negedge clk_i); eng_ready_i = 1'b0;
            #1;
            chk("R6 busy", int'(tx_busy_o), 1);
            chk("R8 plain rx off", int'(rx_en_o), 0);
            finish_tx();
          end
        end
      end
    end
    prio_mode_i = 1'b0;

    // R8 loop-back send
    tx_sel_i = 3'b100;
    wr(5'h10);
    eng_ready_i = 1'b1; #1;
    chk("R8 loop start", int'(tx_start_o), 1);
    chk("R8 loop idx", int'(tx_idx_o), 2);
    @(negedge clk_i); eng_ready_i = 1'b0; #1;
    chk("R8 loop rx on", int'(rx_en_o), 1);
    chk("R8 loop flag", int'(tx_self_o), 1);
    finish_tx();

    // R5 send while pending ignored
    tx_sel_i = 3'b010; wr(5'h01);
    tx_sel_i = 3'b100; wr(5'h01);
    eng_ready_i = 1'b1; #1;
    chk("R5 pending keeps idx", int'(tx_idx_o), 1);
    chk("R5 pending start", int'(tx_start_o), 1);
    @(negedge clk_i); eng_ready_i = 1'b0;
    finish_tx();

    // R7 cancel of other buffer
    tx_sel_i = 3'b010; wr(5'h01);
    tx_sel_i = 3'b001; wr(5'h02);
    eng_ready_i = 1'b1; #1;
    chk("R7 wrong cancel keeps", int'(tx_start_o), 1);
    @(negedge clk_i); eng_ready_i = 1'b0;
    finish_tx();

    // R7 cancel hit
    tx_sel_i = 3'b010; wr(5'h01); wr(5'h02);
    eng_ready_i = 1'b1; #1;
    chk("R7 cancel no start", int'(tx_start_o), 0);
    chk("R7 cancel idle", int'(tx_busy_o), 0);
    @(negedge clk_i); eng_ready_i = 1'b0;

    // R7 cancel wins over ready same cycle
    tx_sel_i = 3'b001; wr(5'h01);
    @(negedge clk_i); cmd_we_i = 1'b1; cmd_wdata_i = 5'h02; eng_ready_i = 1'b1;
    #1 chk("R7 cancel beats ready", int'(tx_start_o), 0);
    @(negedge clk_i); cmd_we_i = 1'b0; cmd_wdata_i = '0; eng_ready_i = 1'b0;
    #1 chk("R7 cancel beats ready idle", int'(tx_busy_o), 0);

    // R7 cancel during active
    tx_sel_i = 3'b001; wr(5'h01);
    eng_ready_i = 1'b1;
    @(negedge clk_i); eng_ready_i = 1'b0;
    wr(5'h02); #1;
    chk("R7 active cancel busy", int'(tx_busy_o), 1);
    chk("R7 active cancel rx off", int'(rx_en_o), 0);
    finish_tx();

    // R2 send in gap cycle ignored
    tx_sel_i = 3'b001;
    @(negedge clk_i); cmd_we_i = 1'b1; cmd_wdata_i = 5'h00;
    @(negedge clk_i); cmd_wdata_i = 5'h01;
    @(negedge clk_i); cmd_we_i = 1'b0; cmd_wdata_i = '0;
    eng_ready_i = 1'b1; #1;
    chk("R2 gap send ignored", int'(tx_start_o), 0);
    chk("R2 gap send idle", int'(tx_busy_o), 0);
    @(negedge clk_i); eng_ready_i = 1'b0;

    // R9 release paths
    frame(); #1 chk("R9 rbs set", int'(rbs_o), 1);
    wr(5'h04);
    chk("R9 release strobe", int'(last_rel), 1);
    #1 chk("R9 rbs cleared", int'(rbs_o), 0);
    wr(5'h04);
    chk("R9 empty release no strobe", int'(last_rel), 0);
    #1 chk("R9 empty release rbs", int'(rbs_o), 0);

    // R10 overrun and drop
    frame(); frame(); frame(); #1;
    chk("R10 overrun", int'(dor_o), 1);
    chk("R10 rbs", int'(rbs_o), 1);
    wr(5'h08); #1 chk("R11 clear", int'(dor_o), 0);
    wr(5'h04); chk("R10 release 1", int'(last_rel), 1);
    wr(5'h04); chk("R10 release 2", int'(last_rel), 1);
    wr(5'h04); chk("R10 dropped frame", int'(last_rel), 0);

    // R11 set wins over clear
    frame(); frame();
    @(negedge clk_i); cmd_we_i = 1'b1; cmd_wdata_i = 5'h08; rx_frame_i = 1'b1;
    @(negedge clk_i); cmd_we_i = 1'b0; cmd_wdata_i = '0; rx_frame_i = 1'b0;
    #1 chk("R11 set wins", int'(dor_o), 1);
    wr(5'h08); #1 chk("R11 clear after", int'(dor_o), 0);

    // R10 release with frame when full: no overrun
    @(negedge clk_i); cmd_we_i = 1'b1; cmd_wdata_i = 5'h04; rx_frame_i = 1'b1;
    @(negedge clk_i); cmd_we_i = 1'b0; cmd_wdata_i = '0; rx_frame_i = 1'b0;
    #1 chk("R10 room made no overrun", int'(dor_o), 0);
    wr(5'h04); chk("R10 kept frame 1", int'(last_rel), 1);
    wr(5'h04); chk("R10 kept frame 2", int'(last_rel), 1);
    wr(5'h04); chk("R10 now empty", int'(last_rel), 0);

    // R2 clear in gap ignored
    frame(); frame(); frame(); #1 chk("R10 overrun again", int'(dor_o), 1);
    @(negedge clk_i); cmd_we_i = 1'b1; cmd_wdata_i = 5'h00;
    @(negedge clk_i); cmd_wdata_i = 5'h08;
    @(negedge clk_i); cmd_we_i = 1'b0; cmd_wdata_i = '0;
    #1 chk("R2 gap clear ignored", int'(dor_o), 1);
    wr(5'h08); #1 chk("R11 clear accepted", int'(dor_o), 0);

    finish_run();
  end
endmodule